// File: doc/BRIEF.md
# Signed-Count Barrel Shift and Rotate Unit

This combinational unit moves the bits of a WIDTH-bit vector left or right, or rotates them, in one pass of logic. A 3-bit operation code picks one of six operations: logical, arithmetic and rotate, each available in both directions. The distance is a signed two's-complement count. A negative count runs the same kind of operation the other way, so a left operation with a count of -k gives the same result as the matching right operation with a count of k.

Logical shifts bring in zeros. An arithmetic right shift copies the most significant bit into the bits it vacates. An arithmetic left shift copies the original least significant bit into the low bits it vacates. Rotates are circular, and they take the count modulo WIDTH. A shift whose distance is WIDTH or more leaves only fill bits. There is no clock, and the output follows the inputs after the logic settles.

Top module: `bsu_shift_unit`

## Requirements
- R1: The op_sel encoding is 0 logical left, 1 logical right, 2 arithmetic left, 3 arithmetic right, 4 rotate left and 5 rotate right. Codes 6 and 7 pass data_in to data_out unchanged.
- R2: Logical shifts fill the vacated bits with 0. With WIDTH=4 and data 1011, a left shift by 1 gives 0110 and a right shift by 1 gives 0101.
- R3: Arithmetic right shift fills the vacated high bits with the input MSB. For 1011, a count of 1 gives 1101 and a count of 3 gives 1111.
- R4: Arithmetic left shift fills the vacated low bits with the input LSB. For 1011, a count of 1 gives 0111 and a count of 3 gives 1111.
- R5: Rotates are circular and keep the number of set bits. For 1011, rotate left by 1 gives 0111, rotate right by 1 gives 1101, rotate left by 3 gives 1101 and rotate right by 3 gives 0111.
- R6: shift_cnt is two's complement of CNT_W bits. A negative count runs the same kind of operation in the opposite direction over the magnitude of the count.
- R7: For the four shift operations, a count magnitude of WIDTH or more makes every output bit the fill bit: 0 for logical shifts, the LSB for an arithmetic left shift, the MSB for an arithmetic right shift.
- R8: Rotates use the count magnitude modulo WIDTH. A magnitude of exactly WIDTH returns the input unchanged.
- R9: A count of zero returns data_in unchanged for every op_sel value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Vector to shift or rotate |
| op_sel | input | 3 | Operation code, encoded as in R1 |
| shift_cnt | input | CNT_W | Signed two's-complement distance |
| data_out | output | WIDTH | Result vector |

## Verification
The bench covers every combination of data, operation code and count for the default widths. This includes the most negative count, -8. Its magnitude cannot be held in a signed field of the same width, and a unit that negates the count in signed arithmetic would shift by zero or in the wrong direction there. Counts of exactly WIDTH are checked for both kinds of operation. A unit that only truncated the count would shift rotates correctly but return the input unchanged for shifts, where it should return only fill bits. An arithmetic left shift that filled with zero, or a reversed direction that lost the arithmetic fill, shows up as a wrong low or high bit on the examples given in R3 and R4.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [2:0] {
    OP_SLL = 3'd0,
    OP_SRL = 3'd1,
    OP_SLA = 3'd2,
    OP_SRA = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5
  } bsu_op_e;

  // Codes above OP_ROR are unused and pass the data through.
  function automatic logic op_valid(input logic [2:0] op);
    return op <= OP_ROR;
  endfunction

  // Natural direction of the code when the count is positive.
  function automatic logic op_left(input logic [2:0] op);
    return (op == OP_SLL) || (op == OP_SLA) || (op == OP_ROL);
  endfunction

  function automatic logic op_arith(input logic [2:0] op);
    return (op == OP_SLA) || (op == OP_SRA);
  endfunction

  function automatic logic op_rotate(input logic [2:0] op);
    return (op == OP_ROL) || (op == OP_ROR);
  endfunction

  // Fill bit for the bits a shift vacates, chosen by the effective direction.
  function automatic logic fill_select(input logic arith, input logic go_left,
                                       input logic lsb, input logic msb);
    if (!arith) return 1'b0;
    return go_left ? lsb : msb;
  endfunction

endpackage

// File: rtl/bsu_count_norm.sv
module bsu_count_norm
  import bsu_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int CNT_W = 4,
  localparam int AMT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic signed [CNT_W-1:0] cnt,
  input  logic [2:0]              op,
  output logic                    go_left,
  output logic                    rot,
  output logic                    sat,
  output logic [AMT_W-1:0]        amt
);

  logic             neg;
  logic [CNT_W-1:0] mag;
  int unsigned      mag_u;

  always_comb begin
    neg = cnt[CNT_W-1];
    // Unsigned negate, so the most negative count keeps its full magnitude.
    mag     = neg ? (~cnt + 1'b1) : cnt;
    mag_u   = 32'(mag);
    rot     = op_rotate(op);
    go_left = op_left(op) ^ neg;
    sat     = !rot && (mag_u >= WIDTH);
    amt     = rot ? AMT_W'(mag_u % WIDTH) : AMT_W'(mag_u);
  end

endmodule

// File: rtl/bsu_barrel.sv
module bsu_barrel #(
  parameter int WIDTH = 4,
  localparam int AMT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amt,
  input  logic             go_left,
  input  logic             rot,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] din_rev;
  logic [WIDTH-1:0] stg [AMT_W+1];
  logic [WIDTH-1:0] last_rev;

  // A right operation is a left operation on the bit-reversed vector.
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign din_rev[i]  = din[WIDTH-1-i];
    assign last_rev[i] = stg[AMT_W][WIDTH-1-i];
  end

  assign stg[0] = go_left ? din : din_rev;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= SH) begin : g_mid
        assign stg[s+1][i] = amt[s] ? stg[s][i-SH] : stg[s][i];
      end else begin : g_edge
        assign stg[s+1][i] = amt[s] ? (rot ? stg[s][i-SH+WIDTH] : fill)
                                    : stg[s][i];
      end
    end
  end

  assign dout = go_left ? stg[AMT_W] : last_rev;

endmodule

// File: rtl/bsu_shift_unit.sv
module bsu_shift_unit
  import bsu_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int CNT_W = 4
) (
  input  logic [WIDTH-1:0]        data_in,
  input  logic [2:0]              op_sel,
  input  logic signed [CNT_W-1:0] shift_cnt,
  output logic [WIDTH-1:0]        data_out
);

  localparam int AMT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  // Named internal events, observed by the bound checker.
  logic             eff_left;
  logic             rot_sel;
  logic             sat_hit;
  logic             fill_bit;
  logic             pass_thru;
  logic [AMT_W-1:0] eff_amt;
  logic [WIDTH-1:0] barrel_out;

  bsu_count_norm #(.WIDTH(WIDTH), .CNT_W(CNT_W)) norm_i (
    .cnt     (shift_cnt),
    .op      (op_sel),
    .go_left (eff_left),
    .rot     (rot_sel),
    .sat     (sat_hit),
    .amt     (eff_amt)
  );

  assign fill_bit  = fill_select(op_arith(op_sel), eff_left,
                                 data_in[0], data_in[WIDTH-1]);
  assign pass_thru = !op_valid(op_sel);

  bsu_barrel #(.WIDTH(WIDTH)) barrel_i (
    .din     (data_in),
    .amt     (eff_amt),
    .go_left (eff_left),
    .rot     (rot_sel),
    .fill    (fill_bit),
    .dout    (barrel_out)
  );

  always_comb begin
    if (pass_thru)    data_out = data_in;
    else if (sat_hit) data_out = {WIDTH{fill_bit}};
    else              data_out = barrel_out;
  end

endmodule

// File: rtl/bsu_shift_unit_chk.sv
module bsu_shift_unit_chk #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 4
) (
  input logic [WIDTH-1:0]        data_in,
  input logic [2:0]              op_sel,
  input logic signed [CNT_W-1:0] shift_cnt,
  input logic [WIDTH-1:0]        data_out,
  input logic                    sat_hit,
  input logic                    eff_left
);

  always_comb begin
    if (shift_cnt == '0)
      AST_ZERO_PASS: assert (data_out == data_in); // R9
    if (op_sel > 3'd5)
      AST_UNUSED_PASS: assert (data_out == data_in); // R1
    if (op_sel == 3'd4 || op_sel == 3'd5)
      AST_ROT_KEEPS_ONES: assert ($countones(data_out) == $countones(data_in)); // R5
    if (sat_hit && (op_sel == 3'd0 || op_sel == 3'd1))
      AST_LOGIC_SAT_ZERO: assert (data_out == '0); // R7
    if (op_sel == 3'd3 && shift_cnt > 0)
      AST_SRA_SIGN_FILL: assert (data_out[WIDTH-1] == data_in[WIDTH-1]); // R3
    if (op_sel == 3'd2 && shift_cnt > 0)
      AST_SLA_LSB_FILL: assert (data_out[0] == data_in[0]); // R4
    if (op_sel == 3'd0 && shift_cnt > 0)
      AST_SLL_ZERO_LOW: assert (data_out[0] == 1'b0); // R2
    if (op_sel == 3'd0 && shift_cnt < 0)
      AST_NEG_REVERSES: assert (!eff_left && data_out[WIDTH-1] == 1'b0); // R6
  end

endmodule

bind bsu_shift_unit bsu_shift_unit_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) chk_i (
  .data_in   (data_in),
  .op_sel    (op_sel),
  .shift_cnt (shift_cnt),
  .data_out  (data_out),
  .sat_hit   (sat_hit),
  .eff_left  (eff_left)
);

// File: tb/bsu_shift_unit_tb.sv
module bsu_shift_unit_tb_top;

  localparam int W  = 4;
  localparam int CW = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [W-1:0]         data_in = '0;
  logic [2:0]           op_sel = '0;
  logic signed [CW-1:0] shift_cnt = '0;
  logic [W-1:0]         data_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
    logic [W-1:0] d;
    logic [2:0]   op;
    int           cnt;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  bsu_shift_unit #(.WIDTH(W), .CNT_W(CW)) dut_i (
    .data_in   (data_in),
    .op_sel    (op_sel),
    .shift_cnt (shift_cnt),
    .data_out  (data_out)
  );

  // Bit-by-bit model: each output bit looks up its source position.
  function automatic logic [W-1:0] model(logic [W-1:0] d, logic [2:0] op, int k);
    logic [W-1:0] r;
    int kk;
    logic fl;
    if (op > 3'd5 || k == 0) return d;
    if (op == 3'd4 || op == 3'd5) begin
      kk = (op == 3'd4) ? k : -k;
      for (int i = 0; i < W; i++) r[i] = d[(((i - kk) % W) + W) % W];
      return r;
    end
    kk = (op == 3'd0 || op == 3'd2) ? k : -k;
    if (kk > 0) begin
      fl = (op == 3'd2 || op == 3'd3) ? d[0] : 1'b0;
      for (int i = 0; i < W; i++) r[i] = (i - kk >= 0) ? d[i-kk] : fl;
    end else begin
      fl = (op == 3'd2 || op == 3'd3) ? d[W-1] : 1'b0;
      for (int i = 0; i < W; i++) r[i] = (i - kk < W) ? d[i-kk] : fl;
    end
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op, int k);
    int m;
    m = (k < 0) ? -k : k;
    if (k == 0) return "R9";
    if (op > 3'd5) return "R1";
    if (op >= 3'd4 && m >= W) return "R8";
    if (op < 3'd4 && m >= W) return "R7";
    if (k < 0) return "R6";
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2:       return "R4";
      3'd3:       return "R3";
      default:    return "R5";
    endcase
  endfunction

  task automatic drive(logic [W-1:0] d, logic [2:0] op, int k,
                       logic [W-1:0] exp, string tag);
    sb_item_t it;
    @(posedge clk);
    #1;
    data_in   = d;
    op_sel    = op;
    shift_cnt = CW'(k);
    it.exp = exp; it.tag = tag; it.d = d; it.op = op; it.cnt = k;
    sb_q.push_back(it);
  endtask

  // Monitor: pops the expectation queued in the same cycle.
  initial begin
    sb_item_t it;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_checks++;
        if (data_out !== it.exp) begin
          n_errors++;
          $display("FAIL %s: d=%b op=%0d cnt=%0d actual=%b expected=%b",
                   it.tag, it.d, it.op, it.cnt, data_out, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Output with all inputs at zero after reset (R9)
    drive(4'b0000, 3'd0, 0, 4'b0000, "R9");
    // Worked examples
    drive(4'b1011, 3'd0, 1, 4'b0110, "R2");
    drive(4'b1011, 3'd1, 1, 4'b0101, "R2");
    drive(4'b1011, 3'd3, 1, 4'b1101, "R3");
    drive(4'b1011, 3'd3, 3, 4'b1111, "R3");
    drive(4'b1011, 3'd2, 1, 4'b0111, "R4");
    drive(4'b1011, 3'd2, 3, 4'b1111, "R4");
    drive(4'b1011, 3'd4, 1, 4'b0111, "R5");
    drive(4'b1011, 3'd5, 1, 4'b1101, "R5");
    drive(4'b1011, 3'd4, 3, 4'b1101, "R5");
    drive(4'b1011, 3'd5, 3, 4'b0111, "R5");
    // Negative counts: same kind, reversed direction
    drive(4'b1011, 3'd0, -1, 4'b0101, "R6");
    drive(4'b1011, 3'd2, -1, 4'b1101, "R6");
    drive(4'b1011, 3'd3, -1, 4'b0111, "R6");
    drive(4'b1011, 3'd4, -3, 4'b0111, "R6");
    // Saturating shifts and modulo rotates
    drive(4'b1011, 3'd0, 4, 4'b0000, "R7");
    drive(4'b0110, 3'd3, -8, 4'b0000, "R7");
    drive(4'b1010, 3'd1, -8, 4'b0000, "R7");
    drive(4'b1011, 3'd4, 4, 4'b1011, "R8");
    drive(4'b1011, 3'd5, -8, 4'b1011, "R8");
    drive(4'b1011, 3'd5, 5, 4'b1101, "R8");
    // Unused codes
    drive(4'b1011, 3'd6, 2, 4'b1011, "R1");
    drive(4'b0110, 3'd7, -3, 4'b0110, "R1");
    // Full sweep against the model
    for (int d = 0; d < (1 << W); d++)
      for (int op = 0; op < 8; op++)
        for (int k = -(1 << (CW-1)); k < (1 << (CW-1)); k++)
          drive(W'(d), 3'(op), k, model(W'(d), 3'(op), k), tag_of(3'(op), k));
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule